// File: doc/BRIEF.md
# MESI Snooping L1 Cache Controller

This block is the coherence controller for one core's private L1 data cache. It tracks a tag and a MESI state (Invalid, Shared, Exclusive, Modified) for every line of a 4-way set-associative array. Replacement is true least-recently-used. The core presents one access at a time: a read or a write of an 8-byte word, identified by the line that contains it. A copy operation is issued by the core as a read followed by a write. The controller works out from the stored state whether the access can finish locally. If it cannot, it sends a coherence request on a shared split-transaction bus.

Bus requests are read, read-for-ownership, upgrade and writeback. The bus either accepts a request into its request table (grant) or refuses it (NACK). On a NACK the controller backs off and sends the same request again. Later the bus signals that the transaction has been broadcast. Only at that point does the controller commit the new line state, taking the fill state from the bus shared line. A snoop port watches the transactions of other cores. It answers with shared and dirty response lines and downgrades or invalidates the local copy. Five event counters record hits, misses, bus messages, accesses that never used the bus, and invalidations caused by snoops.

Top module: `mesi_l1_ctrl`

## Requirements
- R1: After reset every line is Invalid and all five counters are zero. `core_ready` is high and `bus_req_valid` is low. A snoop to any line then gets `snp_shared` low.
- R2: These accesses complete with `core_hit` high and `core_done` pulsed one cycle after acceptance, with no bus request: a read whose line is in S, E or M, and a write whose line is in E or M. Such a write leaves the line in M. Each such access increments `cnt_silent` and `cnt_hit`.
- R3: A read miss requests command 0 (read) for the line. At completion the line is filled in S if `bus_shared` is high in the `bus_done` cycle, and in E otherwise.
- R4: A write miss requests command 1 (read-for-ownership) and fills the line in M. A write to a line in S requests command 2 (upgrade), then finishes in M with `core_hit` high.
- R5: The local state changes only when `bus_done` arrives for this controller's own transaction. A snoop of a missing line while its request is in flight still sees it as absent.
- R6: A request stays asserted with a stable command and line until it is granted or NACKed. After a NACK, `bus_req_valid` is low for exactly RETRY_DLY cycles. The same command and line are then requested again.
- R7: A miss fills an Invalid way if one exists in the set. Otherwise it replaces the least recently used way, where a hit or a fill counts as a use.
- R8: A miss whose victim is in M first issues command 3 (writeback) for the victim's line, then the fill request. A victim in E or S is dropped without any bus message.
- R9: Snoop commands are 0 read, 1 read-for-ownership and 2 upgrade; command 3 is ignored. A snoop hit on a valid line raises `snp_shared`, and raises `snp_dirty` as well if the line is in M. A snooped read moves E or M to S. A snooped read-for-ownership or upgrade invalidates the line and increments `cnt_inval`. A snoop miss changes nothing.
- R10: `cnt_msg` counts granted bus requests, writebacks included. `cnt_hit` counts accesses whose tag was present, and `cnt_miss` counts the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core access request |
| core_req_write | input | 1 | 1 = write, 0 = read |
| core_req_line | input | ADDR_W-LINE_W | Line address of the 8-byte access |
| core_ready | output | 1 | Controller idle, can accept an access |
| core_done | output | 1 | Access finished (one-cycle pulse) |
| core_hit | output | 1 | Tag was present for the finished access |
| bus_req_valid | output | 1 | Coherence request to the bus |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_req_line | output | ADDR_W-LINE_W | Line address of the request |
| bus_grant | input | 1 | Request accepted in this cycle |
| bus_nack | input | 1 | Request refused in this cycle |
| bus_done | input | 1 | Own transaction broadcast and complete |
| bus_shared | input | 1 | Another cache holds the line (valid with bus_done) |
| snp_valid | input | 1 | Another core's transaction on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_line | input | ADDR_W-LINE_W | Snooped line address |
| snp_shared | output | 1 | Local copy present |
| snp_dirty | output | 1 | Local copy modified, data supplied |
| cnt_hit | output | CNT_W | Hit counter |
| cnt_miss | output | CNT_W | Miss counter |
| cnt_msg | output | CNT_W | Granted bus message counter |
| cnt_silent | output | CNT_W | Accesses done without the bus |
| cnt_inval | output | CNT_W | Snoop-caused invalidations |

## Verification
The bench builds the block with four sets and a three-cycle retry delay, and answers bus requests after a four-cycle latency. With only four sets it can fill a set completely and make each of the four ways in turn the least recently used one. That covers every replacement choice, including a Modified victim that needs a writeback. The short latency leaves time to snoop a line while its own fill is still in flight, and the short retry delay lets the NACK back-off be measured cycle by cycle.

// File: rtl/mesi_l1_ctrl.sv
module mesi_l1_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int SET_W     = 2,
  parameter int LINE_W    = 6,
  parameter int CNT_W     = 16,
  parameter int RETRY_DLY = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     core_req_valid,
  input  logic                     core_req_write,
  input  logic [ADDR_W-LINE_W-1:0] core_req_line,
  output logic                     core_ready,
  output logic                     core_done,
  output logic                     core_hit,
  output logic                     bus_req_valid,
  output logic [1:0]               bus_req_cmd,
  output logic [ADDR_W-LINE_W-1:0] bus_req_line,
  input  logic                     bus_grant,
  input  logic                     bus_nack,
  input  logic                     bus_done,
  input  logic                     bus_shared,
  input  logic                     snp_valid,
  input  logic [1:0]               snp_cmd,
  input  logic [ADDR_W-LINE_W-1:0] snp_line,
  output logic                     snp_shared,
  output logic                     snp_dirty,
  output logic [CNT_W-1:0]         cnt_hit,
  output logic [CNT_W-1:0]         cnt_miss,
  output logic [CNT_W-1:0]         cnt_msg,
  output logic [CNT_W-1:0]         cnt_silent,
  output logic [CNT_W-1:0]         cnt_inval
);
  localparam int SETS  = 1 << SET_W;
  localparam int WAYS  = 4;
  localparam int LA_W  = ADDR_W - LINE_W;
  localparam int TAG_W = LA_W - SET_W;
  localparam int BO_W  = $clog2(RETRY_DLY + 1);

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_UPG = 2'd2, CMD_WB = 2'd3;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_BACK, F_WAIT} fsm_t;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [1:0]       mst_q [SETS][WAYS];
  logic [1:0]       age_q [SETS][WAYS];

  fsm_t             fsm_q;
  logic [SET_W-1:0] req_set_q;
  logic [TAG_W-1:0] req_tag_q;
  logic [1:0]       req_way_q;
  logic [1:0]       cmd_q, fill_cmd_q;
  logic [LA_W-1:0]  line_q;
  logic             was_hit_q, done_q, hit_q;
  logic [BO_W-1:0]  bo_q;

  wire [SET_W-1:0] c_set = core_req_line[SET_W-1:0];
  wire [TAG_W-1:0] c_tag = core_req_line[LA_W-1 -: TAG_W];
  wire [SET_W-1:0] s_set = snp_line[SET_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_line[LA_W-1 -: TAG_W];

  logic       c_hit, s_hit;
  logic [1:0] c_way, c_lru, c_vict, c_st, s_way, s_st;

  always_comb begin
    c_hit = 1'b0; c_way = '0; c_lru = '0;
    s_hit = 1'b0; s_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (mst_q[c_set][w] != ST_I && tag_q[c_set][w] == c_tag) begin
        c_hit = 1'b1; c_way = 2'(w);
      end
      if (age_q[c_set][w] == 2'd3) c_lru = 2'(w);
      if (mst_q[s_set][w] != ST_I && tag_q[s_set][w] == s_tag) begin
        s_hit = 1'b1; s_way = 2'(w);
      end
    end
    c_vict = c_lru;
    for (int w = WAYS - 1; w >= 0; w--)
      if (mst_q[c_set][w] == ST_I) c_vict = 2'(w);
    c_st = mst_q[c_set][c_way];
    s_st = mst_q[s_set][s_way];
  end

  assign core_ready    = (fsm_q == F_IDLE);
  assign core_done     = done_q;
  assign core_hit      = hit_q;
  assign bus_req_valid = (fsm_q == F_REQ);
  assign bus_req_cmd   = cmd_q;
  assign bus_req_line  = line_q;
  assign snp_shared    = snp_valid & s_hit;
  assign snp_dirty     = snp_valid & s_hit & (s_st == ST_M);

  wire local_hit = (fsm_q == F_IDLE) && core_req_valid && c_hit && (!core_req_write || c_st[1]);
  wire commit    = (fsm_q == F_WAIT) && bus_done && (cmd_q != CMD_WB);
  wire snp_kill  = snp_valid && s_hit && (snp_cmd == CMD_RDX || snp_cmd == CMD_UPG);

  wire             touch     = local_hit || commit;
  wire [SET_W-1:0] touch_set = (fsm_q == F_IDLE) ? c_set : req_set_q;
  wire [1:0]       touch_way = (fsm_q == F_IDLE) ? c_way : req_way_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= 2'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 2'd1;
      age_q[touch_set][touch_way] <= 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          mst_q[s][w] <= ST_I;
          tag_q[s][w] <= '0;
        end
      fsm_q <= F_IDLE;
      req_set_q <= '0; req_tag_q <= '0; req_way_q <= '0;
      cmd_q <= CMD_RD; fill_cmd_q <= CMD_RD; line_q <= '0;
      was_hit_q <= 1'b0; done_q <= 1'b0; hit_q <= 1'b0; bo_q <= '0;
      cnt_hit <= '0; cnt_miss <= '0; cnt_msg <= '0; cnt_silent <= '0; cnt_inval <= '0;
    end else begin
      done_q <= 1'b0;
      if (snp_valid && s_hit && snp_cmd == CMD_RD && s_st != ST_S)
        mst_q[s_set][s_way] <= ST_S;
      if (snp_kill) begin
        mst_q[s_set][s_way] <= ST_I;
        cnt_inval <= cnt_inval + 1'b1;
      end
      case (fsm_q)
        F_IDLE: if (core_req_valid) begin
          req_set_q <= c_set;
          req_tag_q <= c_tag;
          if (c_hit) begin
            cnt_hit <= cnt_hit + 1'b1;
            if (local_hit) begin
              if (core_req_write) mst_q[c_set][c_way] <= ST_M;
              done_q <= 1'b1; hit_q <= 1'b1;
              cnt_silent <= cnt_silent + 1'b1;
            end else begin
              cmd_q <= CMD_UPG; line_q <= core_req_line;
              req_way_q <= c_way; was_hit_q <= 1'b1; fsm_q <= F_REQ;
            end
          end else begin
            cnt_miss <= cnt_miss + 1'b1;
            req_way_q <= c_vict; was_hit_q <= 1'b0; fsm_q <= F_REQ;
            fill_cmd_q <= core_req_write ? CMD_RDX : CMD_RD;
            if (mst_q[c_set][c_vict] == ST_M) begin
              cmd_q <= CMD_WB; line_q <= {tag_q[c_set][c_vict], c_set};
            end else begin
              cmd_q <= core_req_write ? CMD_RDX : CMD_RD; line_q <= core_req_line;
            end
          end
        end
        F_REQ: if (bus_grant) begin
          cnt_msg <= cnt_msg + 1'b1; fsm_q <= F_WAIT;
        end else if (bus_nack) begin
          bo_q <= BO_W'(RETRY_DLY - 1); fsm_q <= F_BACK;
        end
        F_BACK: if (bo_q == '0) fsm_q <= F_REQ; else bo_q <= bo_q - 1'b1;
        F_WAIT: if (bus_done) begin
          if (cmd_q == CMD_WB) begin
            mst_q[req_set_q][req_way_q] <= ST_I;
            cmd_q <= fill_cmd_q; line_q <= {req_tag_q, req_set_q}; fsm_q <= F_REQ;
          end else begin
            tag_q[req_set_q][req_way_q] <= req_tag_q;
            mst_q[req_set_q][req_way_q] <= (cmd_q == CMD_RD) ? (bus_shared ? ST_S : ST_E) : ST_M;
            done_q <= 1'b1; hit_q <= was_hit_q; fsm_q <= F_IDLE;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesi_l1_ctrl_chk.sv
module mesi_l1_ctrl_chk #(
  parameter int LA_W  = 10,
  parameter int CNT_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_ready,
  input logic            core_done,
  input logic            bus_req_valid,
  input logic [1:0]      bus_req_cmd,
  input logic [LA_W-1:0] bus_req_line,
  input logic            bus_grant,
  input logic            bus_nack,
  input logic            snp_valid,
  input logic [1:0]      snp_cmd,
  input logic            snp_shared,
  input logic [CNT_W-1:0] cnt_msg,
  input logic [CNT_W-1:0] cnt_inval
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_grant && !bus_nack |=> bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_line)); // R6
  AST_NACK_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_nack |=> !bus_req_valid); // R6
  AST_MSG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_grant |=> cnt_msg == $past(cnt_msg) + CNT_W'(1)); // R10
  AST_INVAL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_shared && (snp_cmd == 2'd1 || snp_cmd == 2'd2) |=> cnt_inval == $past(cnt_inval) + CNT_W'(1)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |-> core_ready && !bus_req_valid); // R2
endmodule

bind mesi_l1_ctrl mesi_l1_ctrl_chk #(.LA_W(ADDR_W - LINE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/mesi_l1_ctrl_tb.sv
module mesi_l1_ctrl_tb;
  localparam int LAT = 4;
  localparam int RD  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic core_req_valid = 1'b0, core_req_write = 1'b0;
  logic [9:0] core_req_line = '0;
  logic core_ready, core_done, core_hit;
  logic bus_req_valid; logic [1:0] bus_req_cmd; logic [9:0] bus_req_line;
  logic bus_grant, bus_nack, bus_done = 1'b0, bus_shared;
  logic snp_valid = 1'b0; logic [1:0] snp_cmd = '0; logic [9:0] snp_line = '0;
  logic snp_shared, snp_dirty;
  logic [15:0] cnt_hit, cnt_miss, cnt_msg, cnt_silent, cnt_inval;

  always #5 clk = ~clk;

  mesi_l1_ctrl #(.ADDR_W(16), .SET_W(2), .LINE_W(6), .CNT_W(16), .RETRY_DLY(RD)) u_dut (.*);

  int errors = 0, checks = 0;
  int e_hit = 0, e_miss = 0, e_msg = 0, e_silent = 0, e_inval = 0;
  int n_grant = 0, nack_cnt = 0, nack_req = 0, lat_cnt = 0, gap = 0, last_gap = -1;
  logic in_gap = 1'b0, gap_same = 1'b0, shared_drv = 1'b0;
  logic [1:0] nack_cmd = '0; logic [9:0] nack_line = '0;
  logic [1:0] lg_cmd [32]; logic [9:0] lg_line [32];

  assign bus_shared = shared_drv;
  assign bus_grant  = bus_req_valid && (nack_cnt >= nack_req);
  assign bus_nack   = bus_req_valid && (nack_cnt < nack_req);

  always @(posedge clk) begin
    if (bus_nack) begin
      nack_cnt <= nack_cnt + 1; in_gap <= 1'b1; gap <= 0;
      nack_cmd <= bus_req_cmd; nack_line <= bus_req_line;
    end else if (in_gap) begin
      if (!bus_req_valid) gap <= gap + 1;
      else begin
        in_gap <= 1'b0; last_gap <= gap;
        gap_same <= (bus_req_cmd == nack_cmd) && (bus_req_line == nack_line);
      end
    end
    if (bus_grant) begin
      lg_cmd[n_grant % 32] <= bus_req_cmd; lg_line[n_grant % 32] <= bus_req_line;
      n_grant <= n_grant + 1; lat_cnt <= LAT;
    end else if (lat_cnt != 0) lat_cnt <= lat_cnt - 1;
    bus_done <= (lat_cnt == 1);
  end

  function automatic logic [9:0] ln(input int t, input int s);
    return {8'(t), 2'(s)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [9:0] line, input bit shr,
                        input bit exp_hit, input int exp_msgs, input string req);
    int g0, lat;
    shared_drv = shr;
    @(negedge clk);
    while (!core_ready) @(negedge clk);
    g0 = n_grant;
    core_req_valid = 1'b1; core_req_write = wr; core_req_line = line;
    @(negedge clk);
    core_req_valid = 1'b0; lat = 1;
    while (!core_done && lat < 300) begin @(negedge clk); lat++; end
    chk(core_done, {req, " done"}, int'(core_done), 1);
    chk(core_hit == exp_hit, {req, " hit"}, int'(core_hit), int'(exp_hit));
    chk(n_grant - g0 == exp_msgs, {req, " bus msgs"}, n_grant - g0, exp_msgs);
    if (exp_msgs == 0) chk(lat == 1, {req, " latency"}, lat, 1);
    e_hit += int'(exp_hit); e_miss += int'(!exp_hit); e_msg += exp_msgs;
    e_silent += int'(exp_hit && exp_msgs == 0);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [9:0] line,
                       input bit exp_sh, input bit exp_dt, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_line = line;
    #1;
    chk(snp_shared == exp_sh, {req, " snp_shared"}, int'(snp_shared), int'(exp_sh));
    chk(snp_dirty == exp_dt, {req, " snp_dirty"}, int'(snp_dirty), int'(exp_dt));
    if ((cmd == 2'd1 || cmd == 2'd2) && exp_sh) e_inval++;
    @(posedge clk); #1 snp_valid = 1'b0;
  endtask

  task automatic last_req(input int back, input logic [1:0] cmd, input logic [9:0] line, input string req);
    int i;
    i = (n_grant - back) % 32;
    chk(lg_cmd[i] == cmd, {req, " cmd"}, int'(lg_cmd[i]), int'(cmd));
    chk(lg_line[i] == line, {req, " line"}, int'(lg_line[i]), int'(line));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(core_ready == 1'b1, "R1 ready", int'(core_ready), 1);
    chk(bus_req_valid == 1'b0, "R1 bus idle", int'(bus_req_valid), 0);
    chk(cnt_hit == 0 && cnt_miss == 0 && cnt_msg == 0 && cnt_silent == 0 && cnt_inval == 0,
        "R1 counters", int'(cnt_hit | cnt_miss | cnt_msg | cnt_silent | cnt_inval), 0);
    snoop(2'd0, ln(1, 0), 0, 0, "R1 empty");

    // R3 read miss fills E, R2 silent hits
    access(0, ln(1, 0), 0, 0, 1, "R3 read miss");
    last_req(1, 2'd0, ln(1, 0), "R3 read cmd");
    access(0, ln(1, 0), 0, 1, 0, "R2 read hit E");
    access(1, ln(1, 0), 0, 1, 0, "R2 write E silent");
    snoop(2'd0, ln(1, 0), 1, 1, "R9 read snoop M");
    snoop(2'd0, ln(1, 0), 1, 0, "R9 now S");
    access(0, ln(1, 0), 0, 1, 0, "R2 read hit S");
    access(1, ln(1, 0), 0, 1, 1, "R4 write S upgrade");
    last_req(1, 2'd2, ln(1, 0), "R4 upgrade cmd");
    snoop(2'd0, ln(1, 0), 1, 1, "R4 upgrade gives M");
    snoop(2'd1, ln(1, 0), 1, 0, "R9 rdx snoop");
    snoop(2'd0, ln(1, 0), 0, 0, "R9 invalidated");
    snoop(2'd1, ln(9, 0), 0, 0, "R9 snoop miss");
    snoop(2'd3, ln(2, 3), 0, 0, "R9 cmd3 ignored");

    // R4 write miss
    access(1, ln(2, 1), 0, 0, 1, "R4 write miss");
    last_req(1, 2'd1, ln(2, 1), "R4 rdx cmd");
    snoop(2'd0, ln(2, 1), 1, 1, "R4 fill M");

    // R3 shared fill
    access(0, ln(3, 2), 1, 0, 1, "R3 shared miss");
    access(1, ln(3, 2), 0, 1, 1, "R3 fill was S");
    last_req(1, 2'd2, ln(3, 2), "R3 upgrade after S");

    // R5 commit only at bus_done
    fork
      access(0, ln(4, 2), 0, 0, 1, "R5 miss");
      begin
        int g;
        g = n_grant;
        while (n_grant == g) @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'd0; snp_line = ln(4, 2);
        #1 chk(snp_shared == 1'b0, "R5 in flight", int'(snp_shared), 0);
        checks++;
        @(posedge clk); #1 snp_valid = 1'b0;
      end
    join
    snoop(2'd0, ln(4, 2), 1, 0, "R5 after done");

    // R7 LRU sweep over every way position, R8 silent clean eviction
    for (int k = 0; k < 4; k++) begin
      int base;
      base = 16 + 8 * k;
      for (int j = 0; j < 4; j++) access(0, ln(base + j, 3), 0, 0, 1, "R7 fill");
      for (int j = 0; j < 4; j++) if (j != k) access(0, ln(base + j, 3), 0, 1, 0, "R7 touch");
      access(0, ln(base + 4, 3), 0, 0, 1, "R8 clean evict");
      last_req(1, 2'd0, ln(base + 4, 3), "R8 no writeback");
      for (int j = 0; j < 4; j++) snoop(2'd0, ln(base + j, 3), j != k, 0, "R7 victim");
      for (int j = 0; j < 5; j++) if (j != k) snoop(2'd1, ln(base + j, 3), 1, 0, "R9 cleanup");
    end

    // R8 dirty eviction
    access(1, ln(5, 0), 0, 0, 1, "R8 dirty fill");
    access(0, ln(6, 0), 0, 0, 1, "R8 fill");
    access(0, ln(7, 0), 0, 0, 1, "R8 fill");
    access(0, ln(8, 0), 0, 0, 1, "R8 fill");
    access(0, ln(9, 0), 0, 0, 2, "R8 dirty evict");
    last_req(2, 2'd3, ln(5, 0), "R8 writeback");
    last_req(1, 2'd0, ln(9, 0), "R8 refill");
    snoop(2'd0, ln(5, 0), 0, 0, "R8 victim gone");

    // R6 NACK retry
    begin
      int n0;
      n0 = nack_cnt;
      nack_req = nack_cnt + 2;
      access(0, ln(10, 1), 0, 0, 1, "R6 nacked miss");
      chk(nack_cnt - n0 == 2, "R6 nack count", nack_cnt - n0, 2);
      chk(last_gap == RD, "R6 backoff", last_gap, RD);
      chk(gap_same, "R6 same request", int'(gap_same), 1);
      last_req(1, 2'd0, ln(10, 1), "R6 final cmd");
    end

    // R10 counters
    @(negedge clk);
    chk(cnt_hit == e_hit, "R10 hits", int'(cnt_hit), e_hit);
    chk(cnt_miss == e_miss, "R10 misses", int'(cnt_miss), e_miss);
    chk(cnt_msg == e_msg, "R10 msgs", int'(cnt_msg), e_msg);
    chk(cnt_silent == e_silent, "R2 silent", int'(cnt_silent), e_silent);
    chk(cnt_inval == e_inval, "R9 invals", int'(cnt_inval), e_inval);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule